// File: doc/BRIEF.md
# Sixteen-State Parallel Add-Compare-Select Unit

This block advances the path metrics of a rate 1/2, constraint-length 5 convolutional decoder by one trellis step per clock. The whole trellis step is done in one cycle: eight butterflies run side by side, and each one makes two add-compare-select decisions. Every step yields a sixteen-bit survivor decision vector for a downstream traceback stage, plus the updated set of sixteen path metrics.

Soft symbols arrive eight at a time in a 128-bit word. Each symbol is a signed 16-bit value. Two symbols feed one trellis step, so a single accepted word keeps the unit busy for four consecutive steps. A new word can be taken in the same cycle as the final step of the previous word, so a steady stream of words runs without bubbles. Path metrics are 16-bit unsigned distances, where smaller means more likely. They are rebased whenever the survivor of state zero climbs into the upper half of the range.

Top module: `vit_acs_top`

## Requirements
- R1: While reset is asserted, the state 0 metric is 0, every other metric is 0x1000, and the decision strobe is low.
- R2: A word is accepted on a clock edge where the input strobe is high and the unit is idle or is running its fourth step. The four following cycles each perform one step, and the decision strobe is high exactly in those cycles. Step k uses symbol 2k as the first symbol and symbol 2k+1 as the second, where symbol i occupies bits 16i+15 down to 16i.
- R3: An input strobe during the first three steps of a word is ignored: the word being processed and the step sequence are unchanged.
- R4: For old state o and input bit u, the encoder register is {u, o[3:0]}. The first code bit is the parity of that register ANDed with 5'b10011, and the second code bit is the parity of it ANDed with 5'b11101. The branch distance is ((c0 ? s0 : -s0) + (c1 ? s1 : -s1)) arithmetically shifted right by 9, plus 128.
- R5: New state n is reached from old states 2(n mod 8) and 2(n mod 8)+1 with input bit n[3]. Its candidate metric is the smaller of the two sums of old metric and branch distance.
- R6: Decision bit n is 1 only when the odd old state gives a strictly smaller sum. A tie selects the even state and gives 0.
- R7: When the candidate metric of new state 0 is 0x8000 or more, the smallest of the sixteen candidates is subtracted from all of them before they are stored. Otherwise they are stored unchanged.
- R8: Path metrics and the decision vector hold their values in cycles where no step runs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| inValid | input | 1 | Soft-symbol word offered |
| inWord | input | 128 | Eight signed 16-bit soft symbols |
| decValid | output | 1 | Decision vector strobe, one per step |
| decBits | output | 16 | Survivor decisions, bit n for new state n |
| metricsOut | output | 256 | Sixteen 16-bit path metrics, state n at bits 16n+15:16n |

## Verification
The checks rely on metrics never wrapping between rebases. That holds because the branch distance is at most 256 and metrics cannot spread by more than about four branch distances, so state 0 passes 0x8000 long before any metric nears 0xFFFF. The stimulus uses full-range soft symbols, including the two extreme codes. It streams hundreds of random words so that rebasing happens many times, and it uses all-zero words so that equal-cost ties occur. It also holds the input strobe high through every step, so that the ignored offers and the back-to-back acceptance are both exercised.

// File: rtl/vit_pkg.sv
package vit_pkg;
  localparam int STATE_BITS     = 4;
  localparam int NUM_STATES     = 1 << STATE_BITS;
  localparam int NUM_BFLY       = NUM_STATES / 2;
  localparam int KLEN           = STATE_BITS + 1;
  localparam int SYMS_PER_WORD  = 8;
  localparam int STEPS_PER_WORD = SYMS_PER_WORD / 2;
  localparam int STEP_W         = $clog2(STEPS_PER_WORD);
  localparam int SYM_IDX_W      = $clog2(SYMS_PER_WORD);
  localparam int NUM_CODES      = 4;

  typedef struct packed {
    logic              loadWord;
    logic              stepEn;
    logic              lastStep;
    logic [STEP_W-1:0] stepIdx;
  } ctrl_t;

  function automatic logic [1:0] branchCode(
    input logic [KLEN-1:0]       g0,
    input logic [KLEN-1:0]       g1,
    input logic                  inBit,
    input logic [STATE_BITS-1:0] oldState
  );
    logic [KLEN-1:0] shiftReg;
    shiftReg = {inBit, oldState};
    return {^(shiftReg & g0), ^(shiftReg & g1)};
  endfunction
endpackage

// File: rtl/vit_ctrl.sv
module vit_ctrl
  import vit_pkg::*;
(
  input  logic  clk,
  input  logic  rstN,
  input  logic  inValid,
  output ctrl_t ctrl
);
  logic              busy;
  logic [STEP_W-1:0] stepIdx;
  logic              lastStep;
  logic              accept;

  assign lastStep = busy && (stepIdx == STEP_W'(STEPS_PER_WORD - 1));
  assign accept   = inValid && (!busy || lastStep);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy    <= 1'b0;
      stepIdx <= '0;
    end else if (accept) begin
      busy    <= 1'b1;
      stepIdx <= '0;
    end else if (lastStep) begin
      busy    <= 1'b0;
    end else if (busy) begin
      stepIdx <= stepIdx + 1'b1;
    end
  end

  always_comb begin
    ctrl.loadWord = accept;
    ctrl.stepEn   = busy;
    ctrl.lastStep = lastStep;
    ctrl.stepIdx  = stepIdx;
  end

  // R2
  accept_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    inValid && !busy |=> busy && stepIdx == '0);

  // R3
  step_advance_chk: assert property (@(posedge clk) disable iff (!rstN)
    busy && !lastStep |=> busy && stepIdx == STEP_W'($past(stepIdx) + 1'b1));

  // R2
  word_finish_chk: assert property (@(posedge clk) disable iff (!rstN)
    lastStep && !inValid |=> !busy);
endmodule

// File: rtl/vit_bmu.sv
module vit_bmu
  import vit_pkg::*;
#(
  parameter int SYM_W    = 16,
  parameter int BM_SHIFT = 9,
  localparam int BM_W    = SYM_W + 2 - BM_SHIFT,
  localparam int EXT_W   = SYM_W + 2
) (
  input  logic signed [SYM_W-1:0]        symA,
  input  logic signed [SYM_W-1:0]        symB,
  output logic [NUM_CODES-1:0][BM_W-1:0] bm
);
  localparam logic signed [EXT_W-1:0] BIAS = EXT_W'(1 << (BM_W - 2));

  logic signed [EXT_W-1:0] extA;
  logic signed [EXT_W-1:0] extB;

  assign extA = EXT_W'(symA);
  assign extB = EXT_W'(symB);

  for (genvar c = 0; c < NUM_CODES; c++) begin : g_code
    localparam logic CODE_A = 1'((c >> 1) & 1);
    localparam logic CODE_B = 1'(c & 1);
    logic signed [EXT_W-1:0] termA;
    logic signed [EXT_W-1:0] termB;
    logic signed [EXT_W-1:0] total;
    logic signed [EXT_W-1:0] scaled;
    always_comb begin
      termA  = CODE_A ? extA : -extA;
      termB  = CODE_B ? extB : -extB;
      total  = termA + termB;
      scaled = (total >>> BM_SHIFT) + BIAS;
      bm[c]  = scaled[BM_W-1:0];
    end
  end
endmodule

// File: rtl/vit_bfly.sv
module vit_bfly
  import vit_pkg::*;
#(
  parameter int              PM_W = 16,
  parameter int              BM_W = 9,
  parameter int              IDX  = 0,
  parameter logic [KLEN-1:0] G0   = 5'b10011,
  parameter logic [KLEN-1:0] G1   = 5'b11101
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic [PM_W-1:0]               pmEven,
  input  logic [PM_W-1:0]               pmOdd,
  input  logic [NUM_CODES-1:0][BM_W-1:0] bm,
  output logic [1:0][PM_W-1:0]          pmNew,
  output logic [1:0]                    dec
);
  localparam logic [STATE_BITS-1:0] EVEN_ST = STATE_BITS'(2 * IDX);
  localparam logic [STATE_BITS-1:0] ODD_ST  = STATE_BITS'(2 * IDX + 1);

  for (genvar u = 0; u < 2; u++) begin : g_half
    localparam logic [1:0] CODE_E = branchCode(G0, G1, 1'(u), EVEN_ST);
    localparam logic [1:0] CODE_O = branchCode(G0, G1, 1'(u), ODD_ST);
    logic [PM_W-1:0] candEven;
    logic [PM_W-1:0] candOdd;
    always_comb begin
      candEven = pmEven + PM_W'(bm[CODE_E]);
      candOdd  = pmOdd + PM_W'(bm[CODE_O]);
      dec[u]   = candOdd < candEven;
      pmNew[u] = dec[u] ? candOdd : candEven;
    end

    // R5
    acs_min_chk: assert property (@(posedge clk) disable iff (!rstN)
      pmNew[u] <= candEven && pmNew[u] <= candOdd
      && (pmNew[u] == candEven || pmNew[u] == candOdd));
  end
endmodule

// File: rtl/vit_datapath.sv
module vit_datapath
  import vit_pkg::*;
#(
  parameter int              SYM_W       = 16,
  parameter int              PM_W        = 16,
  parameter int              BM_SHIFT    = 9,
  parameter logic [PM_W-1:0] INIT_METRIC = 16'h1000,
  parameter logic [PM_W-1:0] NORM_LIMIT  = 16'h8000,
  parameter logic [KLEN-1:0] G0          = 5'b10011,
  parameter logic [KLEN-1:0] G1          = 5'b11101,
  localparam int WORD_W = SYM_W * SYMS_PER_WORD,
  localparam int BM_W   = SYM_W + 2 - BM_SHIFT
) (
  input  logic                            clk,
  input  logic                            rstN,
  input  ctrl_t                           ctrl,
  input  logic [WORD_W-1:0]               inWord,
  output logic                            decValid,
  output logic [NUM_STATES-1:0]           decBits,
  output logic [NUM_STATES-1:0][PM_W-1:0] pm
);
  logic [WORD_W-1:0]                wordReg;
  logic signed [SYM_W-1:0]          syms [SYMS_PER_WORD];
  logic signed [SYM_W-1:0]          symA;
  logic signed [SYM_W-1:0]          symB;
  logic [NUM_CODES-1:0][BM_W-1:0]   bm;
  logic [NUM_STATES-1:0][PM_W-1:0]  rawPm;
  logic [NUM_STATES-1:0][PM_W-1:0]  nextPm;
  logic [NUM_STATES-1:0]            decVec;
  logic [PM_W-1:0]                  minPm;
  logic                             normHit;

  function automatic logic hasZero(input logic [NUM_STATES-1:0][PM_W-1:0] v);
    logic found;
    found = 1'b0;
    for (int i = 0; i < NUM_STATES; i++) begin
      if (v[i] == '0) found = 1'b1;
    end
    return found;
  endfunction

  always_comb begin
    for (int i = 0; i < SYMS_PER_WORD; i++) begin
      syms[i] = wordReg[i*SYM_W +: SYM_W];
    end
    symA = syms[{ctrl.stepIdx, 1'b0}];
    symB = syms[{ctrl.stepIdx, 1'b1}];
  end

  vit_bmu #(
    .SYM_W   (SYM_W),
    .BM_SHIFT(BM_SHIFT)
  ) u_bmu (
    .symA(symA),
    .symB(symB),
    .bm  (bm)
  );

  for (genvar j = 0; j < NUM_BFLY; j++) begin : g_bfly
    logic [1:0][PM_W-1:0] pmPair;
    logic [1:0]           decPair;
    vit_bfly #(
      .PM_W(PM_W),
      .BM_W(BM_W),
      .IDX (j),
      .G0  (G0),
      .G1  (G1)
    ) u_bfly (
      .clk   (clk),
      .rstN  (rstN),
      .pmEven(pm[2*j]),
      .pmOdd (pm[2*j+1]),
      .bm    (bm),
      .pmNew (pmPair),
      .dec   (decPair)
    );
    assign rawPm[j]             = pmPair[0];
    assign rawPm[j+NUM_BFLY]    = pmPair[1];
    assign decVec[j]            = decPair[0];
    assign decVec[j+NUM_BFLY]   = decPair[1];
  end

  always_comb begin
    minPm = rawPm[0];
    for (int i = 1; i < NUM_STATES; i++) begin
      if (rawPm[i] < minPm) minPm = rawPm[i];
    end
    normHit = rawPm[0] >= NORM_LIMIT;
    for (int i = 0; i < NUM_STATES; i++) begin
      nextPm[i] = normHit ? rawPm[i] - minPm : rawPm[i];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wordReg <= '0;
    end else if (ctrl.loadWord) begin
      wordReg <= inWord;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_STATES; i++) begin
        pm[i] <= (i == 0) ? '0 : INIT_METRIC;
      end
      decBits  <= '0;
      decValid <= 1'b0;
    end else begin
      decValid <= ctrl.stepEn;
      if (ctrl.stepEn) begin
        pm      <= nextPm;
        decBits <= decVec;
      end
    end
  end

  // R8
  metric_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !ctrl.stepEn |=> $stable(pm) && $stable(decBits));

  // R7
  norm_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.stepEn && normHit |=> hasZero(pm));
endmodule

// File: rtl/vit_acs_top.sv
module vit_acs_top
  import vit_pkg::*;
#(
  parameter int              SYM_W       = 16,
  parameter int              PM_W        = 16,
  parameter int              BM_SHIFT    = 9,
  parameter logic [PM_W-1:0] INIT_METRIC = 16'h1000,
  parameter logic [PM_W-1:0] NORM_LIMIT  = 16'h8000,
  parameter logic [KLEN-1:0] G0          = 5'b10011,
  parameter logic [KLEN-1:0] G1          = 5'b11101,
  localparam int WORD_W = SYM_W * SYMS_PER_WORD,
  localparam int PMV_W  = PM_W * NUM_STATES
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  inValid,
  input  logic [WORD_W-1:0]     inWord,
  output logic                  decValid,
  output logic [NUM_STATES-1:0] decBits,
  output logic [PMV_W-1:0]      metricsOut
);
  ctrl_t                           ctrl;
  logic [NUM_STATES-1:0][PM_W-1:0] pm;

  vit_ctrl u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .inValid(inValid),
    .ctrl   (ctrl)
  );

  vit_datapath #(
    .SYM_W      (SYM_W),
    .PM_W       (PM_W),
    .BM_SHIFT   (BM_SHIFT),
    .INIT_METRIC(INIT_METRIC),
    .NORM_LIMIT (NORM_LIMIT),
    .G0         (G0),
    .G1         (G1)
  ) u_datapath (
    .clk     (clk),
    .rstN    (rstN),
    .ctrl    (ctrl),
    .inWord  (inWord),
    .decValid(decValid),
    .decBits (decBits),
    .pm      (pm)
  );

  assign metricsOut = pm;
endmodule

// File: tb/vit_acs_top_bench.sv
`timescale 1ns/1ps
module vit_acs_top_bench;
  localparam time PERIOD = 8ns;
  localparam logic [4:0] POLY_A = 5'b10011;
  localparam logic [4:0] POLY_B = 5'b11101;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         inValid = 1'b0;
  logic [127:0] inWord = '0;
  logic         decValid;
  logic [15:0]  decBits;
  logic [255:0] metricsOut;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  // reference model state
  int           mPm [16];
  bit           mBusy = 0;
  int           mStep = 0;
  logic [127:0] mWord = '0;
  bit           expValid = 0;
  logic [15:0]  expDec = '0;
  int           normCount = 0;
  int           tieCount = 0;

  vit_acs_top u_vit_acs_top (
    .clk       (clk),
    .rstN      (rstN),
    .inValid   (inValid),
    .inWord    (inWord),
    .decValid  (decValid),
    .decBits   (decBits),
    .metricsOut(metricsOut)
  );

  always #(PERIOD / 2) clk = ~clk;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int distance(input int u, input int oldSt, input int s0, input int s1);
    logic [4:0] r;
    int t;
    r = 5'((u << 4) | oldSt);
    t = ((^(r & POLY_A)) ? s0 : -s0) + ((^(r & POLY_B)) ? s1 : -s1);
    return (t >>> 9) + 128;
  endfunction

  task automatic modelReset();
    for (int i = 0; i < 16; i++) mPm[i] = (i == 0) ? 0 : 32'h1000;
    mBusy = 0;
    mStep = 0;
    expValid = 0;
  endtask

  task automatic modelStep();
    int s0, s1, va, vb, mn;
    int raw [16];
    s0 = int'($signed(mWord[32*mStep +: 16]));
    s1 = int'($signed(mWord[32*mStep + 16 +: 16]));
    for (int n = 0; n < 16; n++) begin
      va = mPm[2*(n % 8)] + distance(n / 8, 2*(n % 8), s0, s1);
      vb = mPm[2*(n % 8) + 1] + distance(n / 8, 2*(n % 8) + 1, s0, s1);
      if (va == vb) tieCount++;
      if (vb < va) begin
        raw[n] = vb;
        expDec[n] = 1'b1;
      end else begin
        raw[n] = va;
        expDec[n] = 1'b0;
      end
    end
    if (raw[0] >= 32768) begin
      normCount++;
      mn = raw[0];
      for (int n = 1; n < 16; n++) if (raw[n] < mn) mn = raw[n];
      for (int n = 0; n < 16; n++) raw[n] = raw[n] - mn;
    end
    for (int n = 0; n < 16; n++) mPm[n] = raw[n] & 32'hFFFF;
  endtask

  initial modelReset();

  always @(posedge clk) begin
    if (!rstN) begin
      modelReset();
    end else begin
      bit acc;
      expValid = mBusy;
      if (mBusy) modelStep();
      acc = inValid && (!mBusy || mStep == 3);
      if (acc) begin
        mWord = inWord;
        mBusy = 1;
        mStep = 0;
      end else if (mBusy && mStep == 3) begin
        mBusy = 0;
      end else if (mBusy) begin
        mStep++;
      end
    end
  end

  // per-cycle comparison, sampled between the edge and the stimulus update
  always @(posedge clk) begin
    #3ns;
    if (rstN && !finished) begin
      check(decValid == expValid, "R2 R3 decValid", decValid, expValid);
      if (expValid) check(decBits == expDec, "R5 R6 decBits", decBits, expDec);
      for (int n = 0; n < 16; n++)
        check(metricsOut[16*n +: 16] == mPm[n][15:0], "R4 R5 R7 R8 metric",
              metricsOut[16*n +: 16], mPm[n][15:0]);
    end
  end

  task automatic checkResetState();
    check(decValid == 1'b0, "R1 decValid in reset", decValid, 0);
    check(metricsOut[15:0] == 16'h0000, "R1 metric0 in reset", metricsOut[15:0], 0);
    for (int n = 1; n < 16; n++)
      check(metricsOut[16*n +: 16] == 16'h1000, "R1 metric in reset",
            metricsOut[16*n +: 16], 16'h1000);
  endtask

  task automatic sendWord(input logic [127:0] w, input int idleCycles);
    @(negedge clk);
    inValid = 1'b1;
    inWord  = w;
    @(negedge clk);
    inValid = 1'b0;
    repeat (idleCycles) @(negedge clk);
  endtask

  function automatic logic [127:0] randWord();
    return {$urandom, $urandom, $urandom, $urandom};
  endfunction

  initial begin
    #(PERIOD * 150000);
    if (!finished) begin
      finished = 1;
      errors++;
      checks++;
      $display("FAIL R2 watchdog actual=hung expected=complete");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    // R1: reset values
    repeat (3) @(negedge clk);
    checkResetState();
    rstN = 1'b1;
    repeat (2) @(negedge clk);

    // R4 R6: all-zero symbols give equal distances, leading to ties
    sendWord('0, 5);
    sendWord('0, 5);
    // R4: hand-picked symbols, including the extreme codes
    sendWord({16'h7FFF, 16'h8000, 16'h8000, 16'h8000, 16'h7FFF, 16'h7FFF, 16'h8000, 16'h7FFF}, 5);
    sendWord({16'd1000, -16'sd2000, 16'd300, 16'd300, -16'sd5, 16'd9000, 16'd0, -16'sd1}, 5);

    // R2 R3: strobe held high through every step, new word every cycle
    @(negedge clk);
    inValid = 1'b1;
    for (int i = 0; i < 40; i++) begin
      inWord = randWord();
      @(negedge clk);
    end
    inValid = 1'b0;
    repeat (6) @(negedge clk);

    // R8: hold when idle
    repeat (10) @(negedge clk);

    // R7: long stream drives metric 0 past the rebase threshold many times
    inValid = 1'b1;
    for (int i = 0; i < 2400; i++) begin
      if (i % 4 == 0) inWord = randWord();
      @(negedge clk);
    end
    inValid = 1'b0;
    repeat (6) @(negedge clk);

    // R1: reset in the middle of a word
    sendWord(randWord(), 0);
    @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    checkResetState();
    rstN = 1'b1;
    sendWord(randWord(), 6);

    check(normCount > 0, "R7 rebase occurred", normCount, 1);
    check(tieCount > 0, "R6 tie occurred", tieCount, 1);

    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule